// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds wall-clock time (seconds, minutes, hours) and a calendar (day, month, two-digit year) as packed BCD digits, together with a day-of-week code. It advances by one second on each cycle where the one-second strobe is high, and it cascades carries through minutes, hours, days, months and years. Month lengths follow the calendar, with February stretched to 29 days whenever the two-digit year is a multiple of four. Hours can be kept in 24-hour form or in 12-hour form, where one bit of the time word marks the afternoon.

Counting is held off after reset until a 32-bit unlock key is written to the key port. From then on the block stays active until the next reset. Software may load the time word, the calendar word and the weekday at any time, before or after unlocking. It would normally load them before writing the key and then let the prescaler's strobe run the clock.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After a synchronous reset, `time_q` is 0x00000000, `cal_q` is 0x00000101 (day 01, month 01, year 00), `wday_q` is 0, `active_q` is 0 and `leap_q` is 1.
- R2: A write on the key port with data 0xA5EB1357 sets `active_q` on the next cycle. Any other value leaves it unchanged, and once set it stays set until reset.
- R3: While `active_q` is 0, the second strobe has no effect on the time, the calendar or the weekday.
- R4: Time word fields are: seconds ones [3:0], seconds tens [6:4], minutes ones [11:8], minutes tens [14:12], hours ones [19:16], hours tens [21:20]. Calendar word fields are: day ones [3:0], day tens [5:4], month ones [11:8], month tens [12], year ones [19:16], year tens [23:20]. All other bits read 0. A load appears on the outputs on the next cycle, is accepted whether or not the block is active, and takes precedence over a strobe in the same cycle.
- R5: On an active strobe, the outputs change on the following cycle. Seconds step 00 to 59 and wrap to 00 with a carry into minutes, and minutes wrap the same way with a carry into hours.
- R6: With `fmt_24h` = 1, hours step 00 to 23, and 23:59:59 wraps to 00:00:00 and advances the calendar by one day.
- R7: With `fmt_24h` = 0, bit 21 of the time word is the PM flag and bit 20 is the hours tens digit. Hours run 12, 01 ... 11, and the PM flag flips when 11 becomes 12. Only 11:59:59 PM rolls into a new day, giving 12:00:00 AM.
- R8: Days wrap after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. When a day wraps it returns to 01 and the month advances, with 12 wrapping to 01 and advancing the year, and year 99 wraps to 00.
- R9: `leap_q` is 1 exactly when the two-digit year is divisible by 4. February wraps after day 29 in such years and after day 28 otherwise.
- R10: The weekday (0 = Sunday ... 6 = Saturday) advances on each day rollover, wraps from 6 to 0, and is loaded from `wday_wdata` by `wday_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_pulse | input | 1 | One-second strobe, one cycle wide |
| fmt_24h | input | 1 | 1 selects 24-hour hours, 0 selects 12-hour with PM flag |
| time_wr | input | 1 | Load strobe for the time word |
| time_wdata | input | 32 | Time word to load |
| cal_wr | input | 1 | Load strobe for the calendar word |
| cal_wdata | input | 32 | Calendar word to load |
| wday_wr | input | 1 | Load strobe for the weekday |
| wday_wdata | input | 3 | Weekday to load |
| key_wr | input | 1 | Write strobe for the unlock key |
| key_wdata | input | 32 | Unlock key data |
| time_q | output | 32 | Current time word |
| cal_q | output | 32 | Current calendar word |
| wday_q | output | 3 | Current weekday |
| leap_q | output | 1 | Current year is a leap year |
| active_q | output | 1 | Block has been unlocked and is counting |

## Verification
On every cycle, the in-line properties check several behaviours. The time must hold steady while no strobe and no load arrives, which covers the locked state. Seconds must wrap from 59, and the 24-hour day must wrap from 23:59:59. The PM flag must flip at 11:59:59 in 12-hour mode. February 29 must roll into March 1. The weekday must wrap from Saturday. The active flag must rise after the key is written and must never fall. Other behaviours can only be shown by the bench's scenarios. These are the month-length table across the year, the December and year-99 carries, the 12-to-01 hour step, the leap flag against the year digits, the exact field layout of loads, and load-over-strobe priority.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

  typedef struct packed {
    logic [1:0] h10;   // bit 1 doubles as PM flag in 12-hour form
    logic [3:0] h1;
    logic [2:0] m10;
    logic [3:0] m1;
    logic [2:0] s10;
    logic [3:0] s1;
  } clk_time_t;

  typedef struct packed {
    logic [3:0] y10;
    logic [3:0] y1;
    logic       mo10;
    logic [3:0] mo1;
    logic [1:0] d10;
    logic [3:0] d1;
  } clk_date_t;

  function automatic logic year_is_leap(input logic [3:0] y10, input logic [3:0] y1);
    if (y10[0]) return (y1 == 4'd2) || (y1 == 4'd6);
    else        return (y1 == 4'd0) || (y1 == 4'd4) || (y1 == 4'd8);
  endfunction

  function automatic logic [5:0] days_in_month(input logic [4:0] mon, input logic leap);
    case (mon)
      5'd2:                      return leap ? 6'd29 : 6'd28;
      5'd4, 5'd6, 5'd9, 5'd11:   return 6'd30;
      default:                   return 6'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_unlock_gate.sv
module rtc_unlock_gate #(
  parameter int          KEY_W = 32,
  parameter logic [31:0] KEY   = 32'hA5EB1357
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_wdata,
  output logic             active_o
);
  localparam logic [KEY_W-1:0] KEY_VAL = KEY[KEY_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)                                active_o <= 1'b0;
    else if (key_wr && key_wdata == KEY_VAL) active_o <= 1'b1;
  end

  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (rst)
    active_o |=> active_o); // R2
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
    (key_wr && key_wdata == KEY_VAL) |=> active_o); // R2
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_bcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_i,
  input  logic      fmt_24h,
  input  logic      load_i,
  input  clk_time_t load_val,
  output clk_time_t cur,
  output logic      day_carry_o
);
  clk_time_t nxt;
  logic sec_max, min_max, roll_day, pm;

  always_comb begin
    nxt      = cur;
    roll_day = 1'b0;
    pm       = cur.h10[1];
    sec_max  = (cur.s10 == 3'd5) && (cur.s1 == 4'd9);
    min_max  = (cur.m10 == 3'd5) && (cur.m1 == 4'd9);
    if (cur.s1 == 4'd9) begin
      nxt.s1  = 4'd0;
      nxt.s10 = (cur.s10 == 3'd5) ? 3'd0 : cur.s10 + 3'd1;
    end else begin
      nxt.s1 = cur.s1 + 4'd1;
    end
    if (sec_max) begin
      if (cur.m1 == 4'd9) begin
        nxt.m1  = 4'd0;
        nxt.m10 = (cur.m10 == 3'd5) ? 3'd0 : cur.m10 + 3'd1;
      end else begin
        nxt.m1 = cur.m1 + 4'd1;
      end
    end
    if (sec_max && min_max) begin
      if (fmt_24h) begin
        if (cur.h10 == 2'd2 && cur.h1 == 4'd3) begin
          nxt.h10 = 2'd0; nxt.h1 = 4'd0; roll_day = 1'b1;
        end else if (cur.h1 == 4'd9) begin
          nxt.h10 = cur.h10 + 2'd1; nxt.h1 = 4'd0;
        end else begin
          nxt.h1 = cur.h1 + 4'd1;
        end
      end else begin
        if (cur.h10[0] && cur.h1 == 4'd1) begin
          nxt.h10 = {~pm, 1'b1}; nxt.h1 = 4'd2; roll_day = pm;
        end else if (cur.h10[0] && cur.h1 == 4'd2) begin
          nxt.h10 = {pm, 1'b0}; nxt.h1 = 4'd1;
        end else if (cur.h1 == 4'd9) begin
          nxt.h10 = {pm, 1'b1}; nxt.h1 = 4'd0;
        end else begin
          nxt.h1 = cur.h1 + 4'd1;
        end
      end
    end
  end

  assign day_carry_o = tick_i & ~load_i & roll_day;

  always_ff @(posedge clk) begin
    if (rst)         cur <= '0;
    else if (load_i) cur <= load_val;
    else if (tick_i) cur <= nxt;
  end

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=> $stable(cur)); // R3
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && cur.s10 == 3'd5 && cur.s1 == 4'd9) |=> (cur.s10 == 3'd0 && cur.s1 == 4'd0)); // R5
  AST_HR24_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && fmt_24h && cur.h10 == 2'd2 && cur.h1 == 4'd3 && sec_max && min_max)
    |=> (cur == '0)); // R6
  AST_PM_FLIP: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && !fmt_24h && cur.h10[0] && cur.h1 == 4'd1 && sec_max && min_max)
    |=> (cur.h10[1] != $past(cur.h10[1]))); // R7
endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
  import rtc_bcd_pkg::*;
#(
  parameter int WDAY_W    = 3,
  parameter int WDAY_LAST = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              day_adv,
  input  logic              cal_load,
  input  clk_date_t         cal_val,
  input  logic              wday_load,
  input  logic [WDAY_W-1:0] wday_val,
  output clk_date_t         date,
  output logic [WDAY_W-1:0] wday_o,
  output logic              leap_o
);
  localparam logic [WDAY_W-1:0] WD_LAST = WDAY_LAST[WDAY_W-1:0];
  localparam clk_date_t DATE_RST = '{y10: 4'd0, y1: 4'd0, mo10: 1'b0, mo1: 4'd1, d10: 2'd0, d1: 4'd1};

  clk_date_t nxt;
  logic [4:0] mon_bin;
  logic [5:0] day_bin, last_day;

  assign leap_o = year_is_leap(date.y10, date.y1);

  always_comb begin
    nxt      = date;
    mon_bin  = date.mo10 ? 5'd10 + {1'b0, date.mo1} : {1'b0, date.mo1};
    day_bin  = {4'd0, date.d10} * 6'd10 + {2'd0, date.d1};
    last_day = days_in_month(mon_bin, leap_o);
    if (day_bin >= last_day) begin
      nxt.d10 = 2'd0; nxt.d1 = 4'd1;
      if (mon_bin >= 5'd12) begin
        nxt.mo10 = 1'b0; nxt.mo1 = 4'd1;
        if (date.y1 == 4'd9) begin
          nxt.y1  = 4'd0;
          nxt.y10 = (date.y10 == 4'd9) ? 4'd0 : date.y10 + 4'd1;
        end else begin
          nxt.y1 = date.y1 + 4'd1;
        end
      end else if (date.mo1 == 4'd9) begin
        nxt.mo10 = 1'b1; nxt.mo1 = 4'd0;
      end else begin
        nxt.mo1 = date.mo1 + 4'd1;
      end
    end else if (date.d1 == 4'd9) begin
      nxt.d10 = date.d10 + 2'd1; nxt.d1 = 4'd0;
    end else begin
      nxt.d1 = date.d1 + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           date <= DATE_RST;
    else if (cal_load) date <= cal_val;
    else if (day_adv)  date <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)            wday_o <= '0;
    else if (wday_load) wday_o <= wday_val;
    else if (day_adv)   wday_o <= (wday_o >= WD_LAST) ? '0 : wday_o + 1'b1;
  end

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    (day_adv && !wday_load && wday_o == WD_LAST) |=> (wday_o == '0)); // R10
  AST_FEB29_END: assert property (@(posedge clk) disable iff (rst)
    (day_adv && !cal_load && mon_bin == 5'd2 && day_bin == 6'd29)
    |=> (date.d10 == 2'd0 && date.d1 == 4'd1 && date.mo10 == 1'b0 && date.mo1 == 4'd3)); // R9
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_bcd_pkg::*;
#(
  parameter int          KEY_W      = 32,
  parameter logic [31:0] UNLOCK_KEY = 32'hA5EB1357,
  parameter int          WDAY_W     = 3,
  parameter int          WDAY_LAST  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_pulse,
  input  logic              fmt_24h,
  input  logic              time_wr,
  input  logic [31:0]       time_wdata,
  input  logic              cal_wr,
  input  logic [31:0]       cal_wdata,
  input  logic              wday_wr,
  input  logic [WDAY_W-1:0] wday_wdata,
  input  logic              key_wr,
  input  logic [KEY_W-1:0]  key_wdata,
  output logic [31:0]       time_q,
  output logic [31:0]       cal_q,
  output logic [WDAY_W-1:0] wday_q,
  output logic              leap_q,
  output logic              active_q
);
  clk_time_t t_load, t_cur;
  clk_date_t c_load, c_cur;
  logic      tick, day_carry;

  wire unused_wbits = ^{time_wdata[31:22], time_wdata[15], time_wdata[7],
                        cal_wdata[31:24], cal_wdata[15:13], cal_wdata[7:6]};

  assign t_load = '{h10: time_wdata[21:20], h1: time_wdata[19:16], m10: time_wdata[14:12],
                    m1: time_wdata[11:8], s10: time_wdata[6:4], s1: time_wdata[3:0]};
  assign c_load = '{y10: cal_wdata[23:20], y1: cal_wdata[19:16], mo10: cal_wdata[12],
                    mo1: cal_wdata[11:8], d10: cal_wdata[5:4], d1: cal_wdata[3:0]};

  assign tick = active_q & sec_pulse;

  rtc_unlock_gate #(.KEY_W(KEY_W), .KEY(UNLOCK_KEY)) u_gate (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_wdata(key_wdata), .active_o(active_q));

  rtc_time_cnt u_time (
    .clk(clk), .rst(rst), .tick_i(tick), .fmt_24h(fmt_24h), .load_i(time_wr),
    .load_val(t_load), .cur(t_cur), .day_carry_o(day_carry));

  rtc_date_cnt #(.WDAY_W(WDAY_W), .WDAY_LAST(WDAY_LAST)) u_date (
    .clk(clk), .rst(rst), .day_adv(day_carry), .cal_load(cal_wr), .cal_val(c_load),
    .wday_load(wday_wr), .wday_val(wday_wdata), .date(c_cur), .wday_o(wday_q), .leap_o(leap_q));

  assign time_q = {10'd0, t_cur.h10, t_cur.h1, 1'b0, t_cur.m10, t_cur.m1, 1'b0, t_cur.s10, t_cur.s1};
  assign cal_q  = {8'd0, c_cur.y10, c_cur.y1, 3'd0, c_cur.mo10, c_cur.mo1, 2'd0, c_cur.d10, c_cur.d1};
endmodule

// File: tb/tb_rtc_bcd_clock.sv
module tb_rtc_bcd_clock;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {req[3:0], fmt, time_in, cal_in, wday_in, time_exp, cal_exp, wday_exp}
  localparam int VW = 4 + 1 + 32 + 32 + 3 + 32 + 32 + 3;

  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd5,  1'b1, 32'h00123456, 32'h00150315, 3'd2, 32'h00123457, 32'h00150315, 3'd2}, // R5 plain second
    {4'd5,  1'b1, 32'h00105959, 32'h00150315, 3'd2, 32'h00110000, 32'h00150315, 3'd2}, // R5 minute/hour carry
    {4'd6,  1'b1, 32'h00235959, 32'h00230315, 3'd3, 32'h00000000, 32'h00230316, 3'd4}, // R6 day wrap
    {4'd8,  1'b1, 32'h00235959, 32'h00230430, 3'd0, 32'h00000000, 32'h00230501, 3'd1}, // R8 30-day month
    {4'd8,  1'b1, 32'h00235959, 32'h00230131, 3'd1, 32'h00000000, 32'h00230201, 3'd2}, // R8 31-day month
    {4'd8,  1'b1, 32'h00235959, 32'h00231231, 3'd0, 32'h00000000, 32'h00240101, 3'd1}, // R8 December
    {4'd8,  1'b1, 32'h00235959, 32'h00991231, 3'd4, 32'h00000000, 32'h00000101, 3'd5}, // R8 year 99
    {4'd9,  1'b1, 32'h00235959, 32'h00230228, 3'd2, 32'h00000000, 32'h00230301, 3'd3}, // R9 Feb non-leap
    {4'd9,  1'b1, 32'h00235959, 32'h00240228, 3'd3, 32'h00000000, 32'h00240229, 3'd4}, // R9 Feb leap 28
    {4'd9,  1'b1, 32'h00235959, 32'h00240229, 3'd4, 32'h00000000, 32'h00240301, 3'd5}, // R9 Feb leap 29
    {4'd10, 1'b1, 32'h00235959, 32'h00230318, 3'd6, 32'h00000000, 32'h00230319, 3'd0}, // R10 Sat to Sun
    {4'd7,  1'b0, 32'h00115959, 32'h00230315, 3'd3, 32'h00320000, 32'h00230315, 3'd3}, // R7 11AM to 12PM
    {4'd7,  1'b0, 32'h00325959, 32'h00230315, 3'd3, 32'h00210000, 32'h00230315, 3'd3}, // R7 12PM to 1PM
    {4'd7,  1'b0, 32'h00315959, 32'h00230315, 3'd3, 32'h00120000, 32'h00230316, 3'd4}, // R7 11PM to 12AM
    {4'd7,  1'b0, 32'h00095959, 32'h00230315, 3'd3, 32'h00100000, 32'h00230315, 3'd3}, // R7 9 to 10
    {4'd7,  1'b0, 32'h00305959, 32'h00230315, 3'd3, 32'h00310000, 32'h00230315, 3'd3}  // R7 10PM to 11PM
  };

  logic        clk = 1'b0, rst = 1'b1, sec_pulse = 1'b0, fmt_24h = 1'b1;
  logic        time_wr = 1'b0, cal_wr = 1'b0, wday_wr = 1'b0, key_wr = 1'b0;
  logic [31:0] time_wdata = '0, cal_wdata = '0, key_wdata = '0;
  logic [2:0]  wday_wdata = '0;
  logic [31:0] time_q, cal_q;
  logic [2:0]  wday_q;
  logic        leap_q, active_q;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_clock dut (
    .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .fmt_24h(fmt_24h),
    .time_wr(time_wr), .time_wdata(time_wdata), .cal_wr(cal_wr), .cal_wdata(cal_wdata),
    .wday_wr(wday_wr), .wday_wdata(wday_wdata), .key_wr(key_wr), .key_wdata(key_wdata),
    .time_q(time_q), .cal_q(cal_q), .wday_q(wday_q), .leap_q(leap_q), .active_q(active_q));

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic exp_leap(input logic [31:0] cal);
    int yr;
    yr = int'(cal[23:20]) * 10 + int'(cal[19:16]);
    return (yr % 4) == 0;
  endfunction

  task automatic tick1();
    @(negedge clk) sec_pulse = 1'b1;
    @(negedge clk) sec_pulse = 1'b0;
  endtask

  task automatic write_key(input logic [31:0] k);
    @(negedge clk) begin key_wr = 1'b1; key_wdata = k; end
    @(negedge clk) key_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "time", time_q, 32'h0);
    chk("R1", "cal", cal_q, 32'h00000101);
    chk("R1", "wday", {29'd0, wday_q}, 32'd0);
    chk("R1", "active", {31'd0, active_q}, 32'd0);
    chk("R1", "leap", {31'd0, leap_q}, 32'd1);
    // R3 strobe ignored while locked
    tick1();
    chk("R3", "time while locked", time_q, 32'h0);
    chk("R3", "cal while locked", cal_q, 32'h00000101);
    // R2 wrong key
    write_key(32'hA5EB1356);
    chk("R2", "active after wrong key", {31'd0, active_q}, 32'd0);
    // R4 load accepted while locked
    @(negedge clk) begin time_wr = 1'b1; time_wdata = 32'hFFC85959; end
    @(negedge clk) time_wr = 1'b0;
    chk("R4", "load while locked", time_q, 32'h00085959);
    tick1();
    chk("R3", "hold after load", time_q, 32'h00085959);
    // R2 correct key
    write_key(32'hA5EB1357);
    chk("R2", "active after key", {31'd0, active_q}, 32'd1);
    tick1();
    chk("R5", "first count", time_q, 32'h00090000);
    // R4 load beats strobe
    @(negedge clk) begin time_wr = 1'b1; time_wdata = 32'h00201010; sec_pulse = 1'b1; end
    @(negedge clk) begin time_wr = 1'b0; sec_pulse = 1'b0; end
    chk("R4", "load over strobe", time_q, 32'h00201010);
    write_key(32'h0);
    chk("R2", "active sticky", {31'd0, active_q}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[VW-1 -: 4], i);
      @(negedge clk) begin
        fmt_24h = v[VW-5];
        time_wr = 1'b1; time_wdata = v[133:102];
        cal_wr  = 1'b1; cal_wdata  = v[101:70];
        wday_wr = 1'b1; wday_wdata = v[69:67];
      end
      @(negedge clk) begin time_wr = 1'b0; cal_wr = 1'b0; wday_wr = 1'b0; sec_pulse = 1'b1; end
      @(negedge clk) sec_pulse = 1'b0;
      chk(tag, "time", time_q, v[66:35]);
      chk(tag, "cal", cal_q, v[34:3]);
      chk(tag, "wday", {29'd0, wday_q}, {29'd0, v[2:0]});
      chk("R9", "leap flag", {31'd0, leap_q}, {31'd0, exp_leap(v[34:3])});
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule